// File: doc/BRIEF.md
# Energy Measurement Record Serializer

This block turns one measurement sample into a variable-length byte record and sends that record out over a byte stream with a valid/ready handshake. Each sample comes with an event code, a microsecond timestamp, a device-state word, a current reading in nA, a voltage reading in mV and an energy reading in µJ. The event code selects which of the four readings go into the record.

Every record starts with an 8-byte header: the event code in the first byte, then 7 timestamp bytes. After the header come only the selected readings, always in the order state, current, voltage, energy. Every multi-byte quantity is sent least-significant byte first.

The serializer holds one record at a time. A sample that arrives while a record is still going out is refused and counted. A sample with an illegal event code is dropped, and a sticky error flag is raised.

Top module: `erec_serializer`

## Requirements
- R1: Byte 0 of a record is the event code zero-extended to 8 bits. Bytes 1 to 7 are the 56-bit timestamp, least-significant byte first.
- R2: Payload fields follow the header in the order state (8 bytes), current (4 bytes), voltage (2 bytes), energy (4 bytes). An absent field is skipped, and each present field goes out least-significant byte first.
- R3: The event code selects the fields as follows:
  - 1: current
  - 2: voltage
  - 3: current and voltage
  - 4: state
  - 5: state and current
  - 6: state and voltage
  - 7: all four fields
  - 8: current, voltage and energy
  - 9: state, current and voltage
- R4: The record length is 8 plus the byte widths of the selected fields. Code 7 therefore gives 26 bytes, and code 2 gives 10 bytes.
- R5: `out_last` is high only on the final byte of a record. After that byte's handshake, `out_valid` is low in the next cycle.
- R6: A byte is consumed only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` and `out_last` hold their values.
- R7: A sample with event code 0 or 10 to 15, offered while the serializer is idle, produces no output. It sets `bad_evt_err`, which stays high until reset.
- R8: A sample offered while `out_valid` is high is ignored, and `ovf_count` is incremented. This includes the cycle in which the final byte is handshaken. `ovf_count` saturates at its maximum value.
- R9: After reset, `out_valid`, `bad_evt_err` and `ovf_count` are all zero.
- R10: A legal sample offered while the serializer is idle is accepted. Its first byte is presented with `out_valid` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_evt | input | 4 | Event code |
| smp_ts | input | 56 | Timestamp in microseconds |
| smp_state | input | 64 | Device-state word |
| smp_cur | input | 32 | Current in nA |
| smp_volt | input | 16 | Voltage in mV |
| smp_energy | input | 32 | Energy in µJ |
| out_ready | input | 1 | Sink accepts the byte |
| out_valid | output | 1 | Byte is available |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Final byte of a record |
| bad_evt_err | output | 1 | Sticky illegal-event flag |
| ovf_count | output | OVF_W | Saturating count of refused samples |

## Verification
A new sample can arrive in the same cycle as the handshake of the final byte of the previous record. In that case the refusal logic and the end-of-record logic act together. The bench provokes this by raising `smp_valid` and `out_ready` together while the final byte is on the output. It then expects three things: `ovf_count` goes up by exactly one, `out_valid` is low in the next cycle, and no new record follows. Refusals in the middle of a record and a long stalled burst that drives the counter into saturation are judged the same way. In both cases the record bytes must come out unchanged.

// File: rtl/erec_pkg.sv
package erec_pkg;
  localparam int TS_BYTES  = 7;
  localparam int ST_W      = 64;
  localparam int CUR_W     = 32;
  localparam int VOLT_W    = 16;
  localparam int EN_W      = 32;
  localparam int HDR_BYTES = 1 + TS_BYTES;
  localparam int MAX_BYTES = HDR_BYTES + (ST_W + CUR_W + VOLT_W + EN_W) / 8;
  localparam int REC_W     = 8 * MAX_BYTES;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef struct packed {
    logic has_st;
    logic has_cur;
    logic has_volt;
    logic has_en;
  } fieldset_t;

  function automatic logic evt_legal(input logic [3:0] evt);
    return (evt >= 4'd1) && (evt <= 4'd9);
  endfunction

  function automatic fieldset_t fields_of(input logic [3:0] evt);
    fieldset_t f;
    case (evt)
      4'd1:    f = '{1'b0, 1'b1, 1'b0, 1'b0};
      4'd2:    f = '{1'b0, 1'b0, 1'b1, 1'b0};
      4'd3:    f = '{1'b0, 1'b1, 1'b1, 1'b0};
      4'd4:    f = '{1'b1, 1'b0, 1'b0, 1'b0};
      4'd5:    f = '{1'b1, 1'b1, 1'b0, 1'b0};
      4'd6:    f = '{1'b1, 1'b0, 1'b1, 1'b0};
      4'd7:    f = '{1'b1, 1'b1, 1'b1, 1'b1};
      4'd8:    f = '{1'b0, 1'b1, 1'b1, 1'b1};
      4'd9:    f = '{1'b1, 1'b1, 1'b1, 1'b0};
      default: f = '{1'b0, 1'b0, 1'b0, 1'b0};
    endcase
    return f;
  endfunction

  function automatic logic [LEN_W-1:0] rec_len(input logic [3:0] evt);
    fieldset_t f;
    int n;
    f = fields_of(evt);
    n = HDR_BYTES;
    if (f.has_st)   n = n + ST_W / 8;
    if (f.has_cur)  n = n + CUR_W / 8;
    if (f.has_volt) n = n + VOLT_W / 8;
    if (f.has_en)   n = n + EN_W / 8;
    return LEN_W'(n);
  endfunction

  function automatic logic [REC_W-1:0] pack_rec(
    input logic [3:0]            evt,
    input logic [8*TS_BYTES-1:0] ts,
    input logic [ST_W-1:0]       st,
    input logic [CUR_W-1:0]      cur,
    input logic [VOLT_W-1:0]     volt,
    input logic [EN_W-1:0]       en
  );
    logic [REC_W-1:0] r;
    fieldset_t f;
    int pos;
    f = fields_of(evt);
    r = '0;
    r[7:0] = {4'b0000, evt};
    r[8 +: 8*TS_BYTES] = ts;
    pos = 8 * HDR_BYTES;
    if (f.has_st)   begin r = r | (REC_W'(st)   << pos); pos = pos + ST_W;   end
    if (f.has_cur)  begin r = r | (REC_W'(cur)  << pos); pos = pos + CUR_W;  end
    if (f.has_volt) begin r = r | (REC_W'(volt) << pos); pos = pos + VOLT_W; end
    if (f.has_en)   begin r = r | (REC_W'(en)   << pos); end
    return r;
  endfunction
endpackage

// File: rtl/erec_pack.sv
module erec_pack
  import erec_pkg::*;
(
  input  logic [3:0]            evt,
  input  logic [8*TS_BYTES-1:0] ts,
  input  logic [ST_W-1:0]       st,
  input  logic [CUR_W-1:0]      cur,
  input  logic [VOLT_W-1:0]     volt,
  input  logic [EN_W-1:0]       en,
  output logic [REC_W-1:0]      rec,
  output logic [LEN_W-1:0]      len,
  output logic                  legal
);
  always_comb begin
    legal = evt_legal(evt);
    len   = rec_len(evt);
    rec   = pack_rec(evt, ts, st, cur, volt, en);
  end
endmodule

// File: rtl/erec_shift.sv
module erec_shift #(
  parameter int unsigned NBYTES = 26,
  parameter int unsigned LW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [8*NBYTES-1:0] rec_in,
  input  logic [LW-1:0]     len_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              idle
);
  logic [8*NBYTES-1:0] sh_q;
  logic [LW-1:0]       rem_q;
  logic                hs;

  assign out_valid = (rem_q != '0);
  assign idle      = (rem_q == '0);
  assign out_last  = (rem_q == LW'(1));
  assign out_data  = sh_q[7:0];
  assign hs        = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load) begin
      sh_q  <= rec_in;
      rem_q <= len_in;
    end else if (hs) begin
      sh_q  <= sh_q >> 8;
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/erec_guard.sv
module erec_guard #(
  parameter int unsigned OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic             idle,
  input  logic             legal,
  output logic             accept,
  output logic             drop_bad,
  output logic             overflow,
  output logic             err_q,
  output logic [OVF_W-1:0] ovf_q
);
  assign accept   = smp_valid & idle & legal;
  assign drop_bad = smp_valid & idle & ~legal;
  assign overflow = smp_valid & ~idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ovf_q <= '0;
    end else begin
      if (drop_bad) err_q <= 1'b1;
      if (overflow && (ovf_q != '1)) ovf_q <= ovf_q + 1'b1;
    end
  end
endmodule

// File: rtl/erec_serializer.sv
module erec_serializer
  import erec_pkg::*;
#(
  parameter int unsigned OVF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [3:0]            smp_evt,
  input  logic [8*TS_BYTES-1:0] smp_ts,
  input  logic [ST_W-1:0]       smp_state,
  input  logic [CUR_W-1:0]      smp_cur,
  input  logic [VOLT_W-1:0]     smp_volt,
  input  logic [EN_W-1:0]       smp_energy,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_last,
  output logic                  bad_evt_err,
  output logic [OVF_W-1:0]      ovf_count
);
  logic [REC_W-1:0] rec_w;
  logic [LEN_W-1:0] len_w;
  logic             legal_w;
  logic             idle_w;
  logic             accept_w;
  logic             drop_bad_w;
  logic             overflow_w;

  erec_pack u_pack (
    .evt(smp_evt), .ts(smp_ts), .st(smp_state), .cur(smp_cur),
    .volt(smp_volt), .en(smp_energy),
    .rec(rec_w), .len(len_w), .legal(legal_w)
  );

  erec_guard #(.OVF_W(OVF_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .idle(idle_w),
    .legal(legal_w), .accept(accept_w), .drop_bad(drop_bad_w),
    .overflow(overflow_w), .err_q(bad_evt_err), .ovf_q(ovf_count)
  );

  erec_shift #(.NBYTES(MAX_BYTES), .LW(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .rec_in(rec_w),
    .len_in(len_w), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .idle(idle_w)
  );
endmodule

// File: rtl/erec_chk.sv
module erec_chk #(
  parameter int unsigned OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       smp_evt,
  input logic             out_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             bad_evt_err,
  input logic [OVF_W-1:0] ovf_count,
  input logic             accept_w,
  input logic             drop_bad_w,
  input logic             overflow_w
);
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> out_valid && (out_data == {4'b0000, $past(smp_evt)})); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R6

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid); // R5

  AST_BAD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_bad_w |=> bad_evt_err); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt_err |=> bad_evt_err); // R7

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !accept_w); // R8

  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_w && (ovf_count != '1) |=> ovf_count == OVF_W'($past(ovf_count) + 1'b1)); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow_w |=> $stable(ovf_count)); // R8
endmodule

bind erec_serializer erec_chk #(.OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_evt(smp_evt), .out_ready(out_ready),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .bad_evt_err(bad_evt_err), .ovf_count(ovf_count), .accept_w(accept_w),
  .drop_bad_w(drop_bad_w), .overflow_w(overflow_w)
);

// File: tb/tb_erec_serializer.sv
module tb_erec_serializer;
  localparam int OVF_W = 3;
  localparam int OVF_MAX = (1 << OVF_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [3:0]  smp_evt = '0;
  logic [55:0] smp_ts = '0;
  logic [63:0] smp_state = '0;
  logic [31:0] smp_cur = '0;
  logic [15:0] smp_volt = '0;
  logic [31:0] smp_energy = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        bad_evt_err;
  logic [OVF_W-1:0] ovf_count;

  int n_chk = 0;
  int n_fail = 0;
  int ovf_exp = 0;
  logic [7:0] lfsr = 8'hA5;
  logic [7:0] exp_b [0:31];
  int exp_n;

  always #5 clk = ~clk;

  erec_serializer #(.OVF_W(OVF_W)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_evt(smp_evt),
    .smp_ts(smp_ts), .smp_state(smp_state), .smp_cur(smp_cur),
    .smp_volt(smp_volt), .smp_energy(smp_energy), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .bad_evt_err(bad_evt_err), .ovf_count(ovf_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b);
    exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic build_exp(input logic [3:0] evt);
    bit s, i, v, e;
    s = (evt == 4) || (evt == 5) || (evt == 6) || (evt == 7) || (evt == 9);
    i = (evt == 1) || (evt == 3) || (evt == 5) || (evt == 7) || (evt == 8) || (evt == 9);
    v = (evt == 2) || (evt == 3) || (evt == 6) || (evt == 7) || (evt == 8) || (evt == 9);
    e = (evt == 7) || (evt == 8);
    exp_n = 0;
    push({4'h0, evt});
    for (int k = 0; k < 7; k++) push(8'((smp_ts >> (8 * k)) & 56'hFF));
    if (s) for (int k = 0; k < 8; k++) push(8'((smp_state >> (8 * k)) & 64'hFF));
    if (i) for (int k = 0; k < 4; k++) push(8'((smp_cur >> (8 * k)) & 32'hFF));
    if (v) for (int k = 0; k < 2; k++) push(8'((smp_volt >> (8 * k)) & 16'hFF));
    if (e) for (int k = 0; k < 4; k++) push(8'((smp_energy >> (8 * k)) & 32'hFF));
  endtask

  task automatic set_fields(input logic [3:0] evt);
    smp_evt    = evt;
    smp_ts     = 56'hA1B2C3D4E5F607 ^ {52'h0, evt};
    smp_state  = 64'h0123456789ABCDEF + {60'h0, evt};
    smp_cur    = 32'hCAFE1200 | {28'h0, evt};
    smp_volt   = 16'h7E30 ^ {12'h0, evt};
    smp_energy = 32'h55AA0000 + 32'(evt) * 3;
  endtask

  // inj_at: byte index at which a busy sample is offered (-1: none)
  // inj_last: offer a sample together with the final-byte handshake
  // burst: stalled cycles with a sample offered before draining
  task automatic run_rec(input logic [3:0] evt, input int inj_at, input bit inj_last, input int burst);
    int idx;
    bit done;
    bit rdy;
    @(negedge clk);
    set_fields(evt);
    build_exp(evt);
    smp_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(out_valid == 1'b1, "R10 first byte valid after accept", out_valid, 1);
    for (int k = 0; k < burst; k++) begin
      smp_valid = 1'b1;
      smp_evt = 4'd3;
      out_ready = 1'b0;
      @(negedge clk);
      chk(out_data == exp_b[0] && out_valid, "R6 held while stalled", out_data, exp_b[0]);
      ovf_exp = (ovf_exp + 1 > OVF_MAX) ? OVF_MAX : ovf_exp + 1;
    end
    smp_valid = 1'b0;
    idx = 0;
    done = 1'b0;
    while (idx < exp_n) begin
      chk(out_valid == 1'b1, "R4 valid during record", out_valid, 1);
      chk(out_data == exp_b[idx], (idx < 8) ? "R1 header byte" : "R2 R3 payload byte",
          out_data, exp_b[idx]);
      chk(out_last == (idx == exp_n - 1), "R5 R4 last flag position", out_last, (idx == exp_n - 1));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy = lfsr[0] | lfsr[2];
      smp_valid = 1'b0;
      if (inj_at >= 0 && idx == inj_at && !done) begin
        smp_valid = 1'b1;
        smp_evt = 4'd5;
        done = 1'b1;
        ovf_exp = (ovf_exp + 1 > OVF_MAX) ? OVF_MAX : ovf_exp + 1;
      end
      if (inj_last && idx == exp_n - 1) begin
        rdy = 1'b1;
        smp_valid = 1'b1;
        smp_evt = 4'd7;
        ovf_exp = (ovf_exp + 1 > OVF_MAX) ? OVF_MAX : ovf_exp + 1;
      end
      out_ready = rdy;
      @(negedge clk);
      smp_valid = 1'b0;
      if (rdy) idx++;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R5 R8 idle after last byte", out_valid, 0);
    chk(int'(ovf_count) == ovf_exp, "R8 overflow count", ovf_count, ovf_exp);
  endtask

  task automatic drop_bad(input logic [3:0] evt);
    @(negedge clk);
    set_fields(evt);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    chk(out_valid == 1'b0, "R7 no output for bad code", out_valid, 0);
    chk(bad_evt_err == 1'b1, "R7 error flag set", bad_evt_err, 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 still no output", out_valid, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", out_valid, 0);
    chk(bad_evt_err == 1'b0, "R9 reset error", bad_evt_err, 0);
    chk(ovf_count == '0, "R9 reset overflow", ovf_count, 0);
    for (int ev = 0; ev < 16; ev++) begin
      if (ev >= 1 && ev <= 9) run_rec(4'(ev), -1, 1'b0, 0);
      else drop_bad(4'(ev));
    end
    run_rec(4'd7, 5, 1'b0, 0);
    run_rec(4'd9, -1, 1'b1, 0);
    run_rec(4'd2, 0, 1'b1, 0);
    run_rec(4'd7, -1, 1'b0, 12);
    chk(int'(ovf_count) == OVF_MAX, "R8 saturation", ovf_count, OVF_MAX);
    chk(bad_evt_err == 1'b1, "R7 error remains sticky", bad_evt_err, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule